// File: doc/BRIEF.md
# Upset-Tolerant Dual-Latch Register with Agreement Voter

This block is a storage register that keeps its output correct when a single stored bit is upset, for example by a particle strike. Every bit keeps two copies of the stored value in two latches. Both latches take the same data and the same transparency control. A state-holding agreement element, known as a Muller C-element, combines the two copies. When the copies agree, it passes their common value to the output. When they disagree, it keeps the value it last produced. The block is built behaviourally for RTL simulation.

Each latch is modelled as a register clocked by a fast system clock `clk`. It is open while `transp` is high and closed while `transp` is low. Each latch has its own upset-injection mask. A bit set in a mask for one `clk` cycle while the latch is closed inverts that stored bit. The inverted value stays until the latch next opens. The register is parameterised in width, and every bit has its own voter.

Top module: `dual_latch_celem_reg`

## Requirements
- R1: While `rst_n` is low, and after it is released with `transp` low, `dout` is all zeros. Reset clears both latch copies and the voter state.
- R2: While `transp` is high, `dout` equals `din` in the same cycle, without waiting for a `clk` edge.
- R3: When `transp` falls, `dout` keeps the value `din` had at the last rising `clk` edge with `transp` high.
- R4: While `transp` is low, changes on `din` have no effect on `dout`.
- R5: While `transp` is low, an upset pulse applied to only one latch copy of a bit leaves that bit of `dout` unchanged.
- R6: While `transp` is high, `upset_a` and `upset_b` have no effect.
  - During that time, `dout` still equals `din`.
  - After `transp` falls, `dout` equals the loaded value.
- R7: If both latch copies of a bit are upset in the same cycle while `transp` is low, that bit of `dout` inverts right after the `clk` edge.
- R8: Upsets on the two copies in different cycles are also voted bit by bit.
  - Upsetting copy A with mask `ma`, then copy B with mask `mb`, gives `dout = d ^ (ma & mb)`.
  - Upsetting copy A with `ma` a second time leaves `dout` at that value, because the re-flipped bits disagree again and their voter holds.
- R9: A new transparent phase reloads both copies and removes every earlier upset. After `transp` falls, `dout` equals the newly loaded value.
- R10: The bits are independent. An upset mask changes only the bits that it selects, as given by the formulas in R7 and R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples latch state and voter state |
| rst_n | input | 1 | Asynchronous active-low reset |
| transp | input | 1 | High: both latches are transparent. Low: both latches hold |
| din | input | WIDTH | Data input shared by both latch copies |
| upset_a | input | WIDTH | Per-bit inversion request for latch copy A; acts only while `transp` is low |
| upset_b | input | WIDTH | Per-bit inversion request for latch copy B; acts only while `transp` is low |
| dout | output | WIDTH | Voted register output |

## Verification
The bench builds the register with WIDTH = 4, so the sweep can cover every data value and every pair of upset masks on the two copies: 16 × 16 × 16 combinations. At this size every mix of agreeing bits, disagreeing bits and untouched bits appears within one word. This shows that the voting is bitwise. It also exercises both the single-copy hold case and the double-upset flip case for each bit position. Each combination also checks that transparency passes data through, that changes on `din` are ignored while holding, that upsets are ignored while the latches are open, and that a reload removes earlier upsets.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

   // Agreement rule of a C-element: pass a common value, otherwise keep the previous one.
   function automatic logic celem_rule(input logic a, input logic b, input logic prev);
      return (a == b) ? a : prev;
   endfunction

endpackage

// File: rtl/dlc_latch.sv
module dlc_latch #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             transp,
   input  logic [WIDTH-1:0] d,
   input  logic [WIDTH-1:0] flip,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] store_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         store_q <= '0;
      else if (transp)
         store_q <= d;
      else
         store_q <= store_q ^ flip;
   end

   // Transparent: input flows straight through. Closed: the stored value drives the output.
   assign q = transp ? d : store_q;

endmodule

// File: rtl/dlc_celem.sv
module dlc_celem (
   input  logic clk,
   input  logic rst_n,
   input  logic a,
   input  logic b,
   output logic y
);
   import dlc_pkg::*;

   logic held_q;

   assign y = celem_rule(a, b, held_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         held_q <= 1'b0;
      else
         held_q <= y;
   end

endmodule

// File: rtl/dual_latch_celem_reg.sv
module dual_latch_celem_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             transp,
   input  logic [WIDTH-1:0] din,
   input  logic [WIDTH-1:0] upset_a,
   input  logic [WIDTH-1:0] upset_b,
   output logic [WIDTH-1:0] dout
);

   localparam int LAST_BIT = WIDTH - 1;

   if (WIDTH < 1) begin : g_bad_width
      $error("dual_latch_celem_reg: WIDTH must be at least 1");
   end

   logic [LAST_BIT:0] copy_a;
   logic [LAST_BIT:0] copy_b;

   dlc_latch #(.WIDTH(WIDTH)) u_lat_a (
      .clk   (clk),
      .rst_n (rst_n),
      .transp(transp),
      .d     (din),
      .flip  (upset_a),
      .q     (copy_a)
   );

   dlc_latch #(.WIDTH(WIDTH)) u_lat_b (
      .clk   (clk),
      .rst_n (rst_n),
      .transp(transp),
      .d     (din),
      .flip  (upset_b),
      .q     (copy_b)
   );

   for (genvar gi = 0; gi <= LAST_BIT; gi++) begin : g_vote
      dlc_celem u_celem (
         .clk  (clk),
         .rst_n(rst_n),
         .a    (copy_a[gi]),
         .b    (copy_b[gi]),
         .y    (dout[gi])
      );
   end

endmodule

// File: rtl/dlc_checker.sv
module dlc_checker #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             transp,
   input logic [WIDTH-1:0] din,
   input logic [WIDTH-1:0] upset_a,
   input logic [WIDTH-1:0] upset_b,
   input logic [WIDTH-1:0] dout
);

   // R1: during reset with the latches closed, the output is cleared
   always_ff @(posedge clk) begin
      if (!rst_n && !transp)
         p_reset_clear_r1: assert (dout == '0);
   end

   p_follow_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
      transp |-> dout == din);

   p_hold_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!transp && $past(!transp) && $past(rst_n) &&
       $past(upset_a) == '0 && $past(upset_b) == '0) |-> $stable(dout));

   p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(transp) && $past(rst_n)) |-> dout == $past(din));

endmodule

bind dual_latch_celem_reg dlc_checker #(.WIDTH(WIDTH)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .transp (transp),
   .din    (din),
   .upset_a(upset_a),
   .upset_b(upset_b),
   .dout   (dout)
);

// File: tb/dual_latch_celem_reg_tb.sv
module dual_latch_celem_reg_tb;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 4;
   localparam int NV         = 1 << W;
   localparam int WATCHDOG   = 150000;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         transp;
   logic [W-1:0] din;
   logic [W-1:0] upset_a;
   logic [W-1:0] upset_b;
   logic [W-1:0] dout;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_latch_celem_reg #(.WIDTH(W)) u_dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .transp (transp),
      .din    (din),
      .upset_a(upset_a),
      .upset_b(upset_b),
      .dout   (dout)
   );

   task automatic check(input string req, input logic [W-1:0] exp);
      checks++;
      if (dout !== exp) begin
         errors++;
         $display("FAIL %s: dout=%h expected=%h", req, dout, exp);
      end
   endtask

   // Drive on the falling edge, then look at the combinational output shortly after.
   task automatic step();
      @(negedge clk);
      #1;
   endtask

   initial begin
      for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n   = 1'b0;
      transp  = 1'b0;
      din     = 4'hA;
      upset_a = '0;
      upset_b = '0;
      #1;
      check("R1", '0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      check("R1", '0);
      rst_n = 1'b1;
      step();
      check("R1", '0);

      for (int d = 0; d < NV; d++) begin
         for (int ma = 0; ma < NV; ma++) begin
            for (int mb = 0; mb < NV; mb++) begin
               logic [W-1:0] dv;
               logic [W-1:0] vote;
               dv   = W'(d);
               vote = dv ^ (W'(ma) & W'(mb));

               // open phase; upsets raised and must be ignored (R6)
               transp  = 1'b1;
               din     = dv;
               upset_a = W'(ma);
               upset_b = W'(mb);
               #1;
               check("R2", dv);
               step();
               check("R6", dv);

               // close; din changes must not matter (R3, R4)
               transp  = 1'b0;
               upset_a = '0;
               upset_b = '0;
               din     = ~dv;
               #1;
               check("R3", dv);
               step();
               check("R4", dv);

               // single copy upset on A (R5)
               upset_a = W'(ma);
               step();
               upset_a = '0;
               check("R5", dv);

               // then copy B: overlapping bits flip (R7, R8, R10)
               upset_b = W'(mb);
               step();
               upset_b = '0;
               if (ma == mb) check("R7", vote);
               else          check("R8", vote);

               // re-flip A: disagreeing bits hold (R8)
               upset_a = W'(ma);
               step();
               upset_a = '0;
               check("R10", vote);

               // reload clears earlier upsets (R9)
               transp = 1'b1;
               din    = dv;
               step();
               transp = 1'b0;
               din    = ~dv;
               #1;
               check("R9", dv);
            end
         end
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule